// File: doc/BRIEF.md
# FIFO Drain Read-Strobe Controller

This block pulls words out of a FIFO on behalf of a consumer. The FIFO's empty flag lags a read by one cycle. The controller produces a registered read enable, and a data-valid pulse one cycle later that marks when the FIFO's output word should be captured. It stops issuing reads once a fixed number of words has been taken. When that number is reached it raises a sticky completion flag.

The empty flag cannot yet reflect a read that is in flight. To cover that gap, the controller looks at its own read strobe from the current cycle. It never delays the empty flag. Two variants are chosen by a parameter:

- **Basic variant:** it never reads in two cycles in a row.
- **Full-rate variant:** it may read back to back while the almost-empty flag says more than one word is held.

Reads are expected to come in short bursts with frequent pauses, because the drain side usually runs faster than the fill side.

Top module: `fifo_drain_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears `fifo_rd_en`, `data_valid`, `word_count` and `done` at the next clock edge.
- R2: `fifo_rd_en` is high in cycle N+1 only if `consumer_ready` was high and `fifo_empty` was low in cycle N.
- R3: With `MODE` set to the basic variant, `fifo_rd_en` is never high in two consecutive cycles.
- R4: With `MODE` set to the full-rate variant, back-to-back reads are issued while `fifo_almost_empty` is low. A cycle that follows a read cycle carries no read if `fifo_almost_empty` was high during that read cycle.
- R5: `data_valid` is high in exactly the cycles that follow a cycle with `fifo_rd_en` high.
- R6: `word_count` rises by one after each read cycle and never exceeds `WORD_LIMIT`.
- R7: `done` goes high in the cycle `word_count` reaches `WORD_LIMIT`. It stays high until reset, and no read is issued while it is high.
- R8: Given a FIFO whose empty flag (occupancy zero) and almost-empty flag (occupancy at most one) reflect a read in the cycle after it, no read is ever issued while the FIFO holds zero words.
- R9: With `consumer_ready` low, no read is issued after the one that may already be in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous start/reset, active high |
| consumer_ready | input | 1 | Consumer can accept words |
| fifo_empty | input | 1 | FIFO holds no word (one-cycle lag after a read) |
| fifo_almost_empty | input | 1 | FIFO holds at most one word |
| fifo_rd_en | output | 1 | Registered read strobe to the FIFO |
| data_valid | output | 1 | FIFO output word is valid this cycle |
| word_count | output | $clog2(WORD_LIMIT+1) | Reads issued since reset |
| done | output | 1 | Word limit reached (sticky) |

## Verification
Both variants are driven side by side from a bench FIFO occupancy model.

- **Preloaded FIFO with a ready consumer:** this separates the variants. Only the full-rate variant may show adjacent read cycles, and both must take exactly the preloaded number of words without underflow.
- **Dropping the ready input mid-stream:** this shows that at most one read is already in flight.
- **Slow trickle fill, one word every third cycle:** this drives the empty flag up and down repeatedly. It shows that the read-feedback rule never underflows, that the counter stops at the limit, and that the completion flag holds against further data.

// File: rtl/drain_pkg.sv
package drain_pkg;
    // Read-issue policy of the drain controller
    typedef enum logic {
        DRAIN_BASIC = 1'b0,   // at most one read every other cycle
        DRAIN_FULL  = 1'b1    // back-to-back reads while more than one word held
    } drain_mode_e;
endpackage

// File: rtl/drain_read_rule.sv
// Combinational read-issue rule; the mode parameter picks the variant.
module drain_read_rule
    import drain_pkg::*;
#(
    parameter drain_mode_e MODE = DRAIN_FULL
) (
    input  logic ready_i,
    input  logic empty_i,
    input  logic almost_empty_i,
    input  logic rd_now_i,      // read strobe present in this cycle
    input  logic room_i,        // word limit not yet consumed
    output logic issue_o
);
    logic feedback_ok;

    generate
        if (MODE == DRAIN_FULL) begin : g_full
            // a read in flight is tolerated only if a second word is held
            assign feedback_ok = !rd_now_i || !almost_empty_i;
        end else begin : g_basic
            assign feedback_ok = !rd_now_i;
        end
    endgenerate

    assign issue_o = ready_i && !empty_i && room_i && feedback_ok;
endmodule

// File: rtl/drain_word_count.sv
// Counts issued reads, reports remaining room and the sticky done flag.
module drain_word_count #(
    parameter int LIMIT = 1024,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_now_i,
    output logic [CW-1:0] count_o,
    output logic          room_o,
    output logic          done_o
);
    localparam logic [CW:0] LIMIT_W = (CW + 1)'(LIMIT);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CW:0] committed;

    always_comb begin
        st_d = st_q;
        if (rd_now_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if ({1'b0, st_d.cnt} == LIMIT_W) begin
            st_d.done = 1'b1;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // words already counted plus the one in flight must leave room
    assign committed = {1'b0, st_q.cnt} + {{CW{1'b0}}, rd_now_i};
    assign room_o    = committed < LIMIT_W;
    assign count_o   = st_q.cnt;
    assign done_o    = st_q.done;
endmodule

// File: rtl/fifo_drain_ctrl.sv
module fifo_drain_ctrl
    import drain_pkg::*;
#(
    parameter int          WORD_LIMIT = 1024,
    parameter drain_mode_e MODE       = DRAIN_FULL,
    localparam int         CW         = $clog2(WORD_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          consumer_ready,
    input  logic          fifo_empty,
    input  logic          fifo_almost_empty,
    output logic          fifo_rd_en,
    output logic          data_valid,
    output logic [CW-1:0] word_count,
    output logic          done
);
    typedef struct packed {
        logic rd;
        logic dv;
    } strobe_t;

    strobe_t st_d, st_q;
    logic    issue;
    logic    room;

    drain_read_rule #(.MODE(MODE)) u_rule (
        .ready_i        (consumer_ready),
        .empty_i        (fifo_empty),
        .almost_empty_i (fifo_almost_empty),
        .rd_now_i       (st_q.rd),
        .room_i         (room),
        .issue_o        (issue)
    );

    drain_word_count #(.LIMIT(WORD_LIMIT), .CW(CW)) u_count (
        .clk      (clk),
        .rst      (rst),
        .rd_now_i (st_q.rd),
        .count_o  (word_count),
        .room_o   (room),
        .done_o   (done)
    );

    always_comb begin
        st_d.rd = issue;
        st_d.dv = st_q.rd;    // FIFO output is valid one cycle after the read
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign fifo_rd_en = st_q.rd;
    assign data_valid = st_q.dv;
endmodule

// File: rtl/fifo_drain_chk.sv
module fifo_drain_chk #(
    parameter int LIMIT = 1024,
    parameter bit FULL  = 1'b1,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          consumer_ready,
    input logic          fifo_empty,
    input logic          fifo_almost_empty,
    input logic          fifo_rd_en,
    input logic          data_valid,
    input logic [CW-1:0] word_count,
    input logic          done
);
    // R2
    read_cause_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_en |-> $past(consumer_ready && !fifo_empty));

    // R3
    basic_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_rd_en && !FULL) |=> !fifo_rd_en);

    // R4
    last_word_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_rd_en && fifo_almost_empty) |=> !fifo_rd_en);

    // R5
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_en |=> data_valid);

    // R5
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !fifo_rd_en |=> !data_valid);

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_en |=> word_count == CW'($past(word_count) + 1'b1));

    // R6
    always_comb begin
        count_cap_chk: assert (rst || int'(word_count) <= LIMIT);
    end

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !fifo_rd_en);
endmodule

bind fifo_drain_ctrl fifo_drain_chk #(
    .LIMIT (WORD_LIMIT),
    .FULL  (MODE == drain_pkg::DRAIN_FULL),
    .CW    (CW)
) u_chk (
    .clk               (clk),
    .rst               (rst),
    .consumer_ready    (consumer_ready),
    .fifo_empty        (fifo_empty),
    .fifo_almost_empty (fifo_almost_empty),
    .fifo_rd_en        (fifo_rd_en),
    .data_valid        (data_valid),
    .word_count        (word_count),
    .done              (done)
);

// File: tb/fifo_drain_ctrl_test.sv
`timescale 1ns/1ps
module fifo_drain_ctrl_test;
    import drain_pkg::*;

    localparam int LIM = 12;
    localparam int CW  = $clog2(LIM + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ready = 1'b0;
    logic wr = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int fails  = 0;

    // FIFO occupancy models (flags reflect a read in the following cycle)
    int occ_f = 0, occ_b = 0;
    logic emp_f, aem_f, emp_b, aem_b;
    assign emp_f = (occ_f == 0);
    assign aem_f = (occ_f <= 1);
    assign emp_b = (occ_b == 0);
    assign aem_b = (occ_b <= 1);

    logic          rd_f, dv_f, done_f, rd_b, dv_b, done_b;
    logic [CW-1:0] cnt_f, cnt_b;

    fifo_drain_ctrl #(.WORD_LIMIT(LIM), .MODE(DRAIN_FULL)) uut (
        .clk(clk), .rst(rst), .consumer_ready(ready),
        .fifo_empty(emp_f), .fifo_almost_empty(aem_f),
        .fifo_rd_en(rd_f), .data_valid(dv_f), .word_count(cnt_f), .done(done_f)
    );

    fifo_drain_ctrl #(.WORD_LIMIT(LIM), .MODE(DRAIN_BASIC)) uut_basic (
        .clk(clk), .rst(rst), .consumer_ready(ready),
        .fifo_empty(emp_b), .fifo_almost_empty(aem_b),
        .fifo_rd_en(rd_b), .data_valid(dv_b), .word_count(cnt_b), .done(done_b)
    );

    always @(posedge clk) begin
        if (rst) begin
            occ_f <= 0;
            occ_b <= 0;
        end else begin
            occ_f <= occ_f + int'(wr) - ((rd_f && occ_f > 0) ? 1 : 0);
            occ_b <= occ_b + int'(wr) - ((rd_b && occ_b > 0) ? 1 : 0);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle monitors
    int  reads_f = 0, reads_b = 0, pair_f = 0, pair_b = 0;
    logic prev_f = 1'b0, prev_b = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            reads_f = 0; reads_b = 0; prev_f = 1'b0; prev_b = 1'b0;
        end else begin
            chk(!(rd_f && occ_f == 0), "R8 full underflow", occ_f, 1);
            chk(!(rd_b && occ_b == 0), "R8 basic underflow", occ_b, 1);
            chk(dv_f == prev_f, "R5 full data_valid", int'(dv_f), int'(prev_f));
            chk(dv_b == prev_b, "R5 basic data_valid", int'(dv_b), int'(prev_b));
            chk(int'(cnt_f) == reads_f, "R6 full count", int'(cnt_f), reads_f);
            chk(int'(cnt_b) == reads_b, "R6 basic count", int'(cnt_b), reads_b);
            if (rd_f && prev_f) pair_f++;
            if (rd_b && prev_b) pair_b++;
            if (rd_f) reads_f++;
            if (rd_b) reads_b++;
            prev_f = rd_f;
            prev_b = rd_b;
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ready = 1'b0; wr = 1'b0;
        cycles(2);
        chk(!rd_f && !dv_f && cnt_f == 0 && !done_f, "R1 full reset", int'(cnt_f), 0);
        chk(!rd_b && !dv_b && cnt_b == 0 && !done_b, "R1 basic reset", int'(cnt_b), 0);
        rst = 1'b0;
    endtask

    task automatic prefill(input int n);
        ready = 1'b0;
        wr = 1'b1;
        cycles(n);
        wr = 1'b0;
        cycles(1);
    endtask

    // Preloaded FIFO, consumer ready: variants differ in read spacing
    task automatic test_preload();
        int base_f, base_b;
        pair_f = 0; pair_b = 0;
        prefill(5);
        chk(reads_f == 0 && reads_b == 0, "R9 no read while not ready", reads_f + reads_b, 0);
        base_f = reads_f; base_b = reads_b;
        ready = 1'b1;
        cycles(20);
        chk(reads_f - base_f == 5, "R4 full drained all", reads_f - base_f, 5);
        chk(reads_b - base_b == 5, "R3 basic drained all", reads_b - base_b, 5);
        chk(pair_f > 0, "R4 full back-to-back seen", pair_f, 1);
        chk(pair_b == 0, "R3 basic never adjacent", pair_b, 0);
        chk(occ_f == 0 && occ_b == 0, "R8 both empty after drain", occ_f + occ_b, 0);
    endtask

    // Consumer drops ready mid-stream
    task automatic test_pause();
        int snap_f, snap_b;
        prefill(6);
        ready = 1'b1;
        cycles(1);
        ready = 1'b0;
        cycles(1);                 // one read may still be in flight
        snap_f = reads_f; snap_b = reads_b;
        cycles(6);
        chk(reads_f == snap_f, "R9 full halted", reads_f - snap_f, 0);
        chk(reads_b == snap_b, "R9 basic halted", reads_b - snap_b, 0);
        chk(occ_f > 0 && occ_b > 0, "R9 words left unread", occ_f, 1);
    endtask

    // Trickle fill (one word every third cycle) until the limit
    task automatic test_trickle();
        int n = 0;
        ready = 1'b1;
        while (!(done_f && done_b) && n < 400) begin
            wr = (n % 3 == 0);
            n++;
            cycles(1);
        end
        wr = 1'b0;
        chk(done_f && int'(cnt_f) == LIM, "R7 full done at limit", int'(cnt_f), LIM);
        chk(done_b && int'(cnt_b) == LIM, "R7 basic done at limit", int'(cnt_b), LIM);
    endtask

    // After the limit: more data, done sticky, no reads
    task automatic test_sticky();
        int snap_f = reads_f, snap_b = reads_b;
        ready = 1'b1;
        prefill(4);
        ready = 1'b1;
        cycles(10);
        chk(reads_f == snap_f && reads_b == snap_b, "R7 no read after limit",
            reads_f + reads_b - snap_f - snap_b, 0);
        chk(done_f && done_b, "R7 done stays set", int'(done_f) + int'(done_b), 2);
        chk(int'(cnt_f) == LIM && int'(cnt_b) == LIM, "R6 count capped", int'(cnt_f), LIM);
    endtask

    initial begin
        do_reset();
        test_preload();
        test_pause();
        do_reset();
        test_trickle();
        test_sticky();
        do_reset();
        cycles(2);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule